// File: doc/BRIEF.md
# Power-Up Configuration Sequencer

This block is the control state machine that takes a programmable device from power-on, or from a reconfiguration request, to the point where configuration data may be loaded. It clears the configuration frames one after another by driving a frame address counter. After power-on it holds a time-out. Once the time-out has expired and no reconfiguration request is pending, it performs one final clearing pass. It then releases its pull on the shared open-drain INIT line.

While any other device on the wired-AND INIT net still pulls it low, the block waits, so the slowest device in a chain sets the pace. After INIT reads high, the block waits two more clocks, latches the mode strap and raises a ready-to-load flag. The bitstream loader takes over from that point.

The power-on time-out is a cycle count. It is four times longer when the mode strap selects master-serial at power-on. A reconfiguration request (active-low) restarts the clear without restarting the time-out. The request and the INIT readback each pass through two flip-flops before the state machine uses them. The mode strap is assumed static and is not synchronized.

Top module: `cfg_powerup_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `clr_en`=1, `init_low`=1, `hdc`=1, `ldc`=0, `done`=0, `load_rdy`=0, `mode_lat`=0 and `frame_addr`=0.
- R2: While `clr_en` is high, `frame_addr` advances by one on every clock and wraps from FRAMES-1 to 0.
- R3: The power-on time-out lasts POR_CYCLES clocks, or POR_CYCLES*MASTER_MULT clocks when `mode_master` is 1 while reset is held. At the end of each pass (an edge on which `frame_addr` is FRAMES-1), clearing continues if the time-out is still running or a request is present. With reset released after edge 0, pass ends fall on edges 16m, and the first clean one is m = ceil((limit+1)/FRAMES).
- R4: After the first clean pass end, exactly one more full pass runs. `init_low` falls (and `clr_en` drops) on the edge that ends that pass, which is FRAMES edges later.
- R5: `hdc`=1 and `ldc`=0 whenever `load_rdy` is 0, and `hdc`=0 and `ldc`=1 when `load_rdy` is 1.
- R6: After releasing INIT, the block stays waiting (`load_rdy`=0) for as long as `init_in` reads low.
- R7: `load_rdy` rises on the fifth rising edge after `init_in` goes high while the block waits: two edges for the synchronizer, one to detect, and two wait clocks. On that edge `mode_lat` takes `mode_master`. If `init_in` is already high when INIT is released, `load_rdy` rises three edges after the release.
- R8: When `prog_n` goes low, the third rising edge afterwards returns the block to clearing from any other state. That edge sets `init_low`=1, `frame_addr`=0, `load_rdy`=0 and `mode_lat`=0. The power-on time-out is not restarted, so the release follows R4 from the first pass end at which the synchronized request has gone away.
- R9: `done` stays 0 throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| prog_n | input | 1 | Active-low reconfiguration request (asynchronous) |
| init_in | input | 1 | Readback of the shared INIT line (asynchronous) |
| mode_master | input | 1 | Mode strap, 1 selects master-serial |
| clr_en | output | 1 | Frame clearing enable |
| frame_addr | output | AW | Frame address being cleared |
| init_low | output | 1 | 1 pulls the open-drain INIT line low |
| hdc | output | 1 | High-during-configuration status |
| ldc | output | 1 | Low-during-configuration status |
| done | output | 1 | Configuration-done status, low in this phase |
| mode_lat | output | 1 | Mode strap latched on entry to ready |
| load_rdy | output | 1 | Configuration data may now be loaded |

## Verification
The bench predicts the exact edge on which INIT is released, both for the master time-out and for the short time-out. A design that skipped the extra pass, tested the timer in the middle of a pass, or ignored the multiplier would release INIT sixteen or more cycles off. A reconfiguration request is held across several pass ends while INIT is held low from outside. This catches a design that restarts the time-out, leaves a stale mode or ready flag, or hands over while INIT is still low. The INIT rise is timed to the edge, which exposes a missing synchronizer stage or a wrong wait count. Mode latching is checked with the strap at both values.

// File: rtl/cps_pkg.sv
// Package: shared types for the power-up configuration sequencer.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package cps_pkg;
    typedef enum logic [2:0] {
        ST_CLEAR = 3'd0,   // clearing frames, time-out or request pending
        ST_EXTRA = 3'd1,   // the single extra clearing pass
        ST_INITW = 3'd2,   // INIT released, waiting for the net to rise
        ST_WAIT2 = 3'd3,   // settle clocks after INIT seen high
        ST_READY = 3'd4    // mode latched, loader may start
    } cps_state_e;
endpackage

// File: rtl/cps_sync.sv
// Module: cps_sync
// Two-flop synchronizer for W independent asynchronous inputs. Each bit
// has its own reset value so that idle levels come out of reset.
// Assumes each input bit is a level that is stable for several clocks.
module cps_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] meta_q;

    // Two stages in series, both loading the idle level on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/cps_frame_ctr.sv
// Module: cps_frame_ctr
// Frame address counter. It advances while run is high, wraps at
// FRAMES-1, and flags the last address so the controller sees pass ends.
// zero has priority and forces address 0. Assumes FRAMES >= 2.
module cps_frame_ctr #(
    parameter int unsigned FRAMES = 16,
    localparam int unsigned AW = (FRAMES > 2) ? $clog2(FRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          zero,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [AW-1:0] LAST_A = AW'(FRAMES - 1);

    assign last = (addr == LAST_A);

    // Address register: clear, hold, or step with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || zero) begin
            addr <= '0;
        end else if (run) begin
            addr <= last ? '0 : addr + 1'b1;
        end
    end
endmodule

// File: rtl/cps_por_timer.sv
// Module: cps_por_timer
// Power-on time-out. It runs only after reset release, never on a
// reconfiguration. The length is chosen from the mode strap while reset is held.
// busy is high until the selected count has elapsed.
module cps_por_timer #(
    parameter int unsigned BASE = 1000,
    parameter int unsigned MULT = 4,
    localparam int unsigned LONG = BASE * MULT,
    localparam int unsigned CW = $clog2(LONG + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master,
    output logic busy
);
    logic [CW-1:0] cnt_q;
    logic          long_q;
    logic [CW-1:0] limit;

    assign limit = long_q ? CW'(LONG) : CW'(BASE);
    assign busy  = (cnt_q != limit);

    // Strap capture during reset; count up to the selected limit after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= master;
        end else if (busy) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfg_powerup_seq.sv
// Module: cfg_powerup_seq (top)
// Memory clear, initialization and hand-off sequencer. It drives the frame
// counter and checks the time-out and the request only at pass ends.
// After that it adds one extra pass, releases INIT, waits for the shared
// line and two settle clocks, then latches the mode strap.
// Assumes: rst_n is synchronous power-on reset; mode_master is a static strap.
module cfg_powerup_seq #(
    parameter int unsigned FRAMES      = 16,
    parameter int unsigned POR_CYCLES  = 1000,
    parameter int unsigned MASTER_MULT = 4,
    parameter int unsigned SETTLE_CLKS = 2,
    localparam int unsigned AW = (FRAMES > 2) ? $clog2(FRAMES) : 1,
    localparam int unsigned WW = (SETTLE_CLKS > 1) ? $clog2(SETTLE_CLKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_n,
    input  logic          init_in,
    input  logic          mode_master,
    output logic          clr_en,
    output logic [AW-1:0] frame_addr,
    output logic          init_low,
    output logic          hdc,
    output logic          ldc,
    output logic          done,
    output logic          mode_lat,
    output logic          load_rdy
);
    import cps_pkg::*;

    localparam logic [WW-1:0] WAIT_LAST = WW'(SETTLE_CLKS - 1);

    cps_state_e    state, state_n;
    logic [1:0]    sync_q;
    logic          prog_req;
    logic          init_hi;
    logic          frame_last;
    logic          por_busy;
    logic          ctr_zero;
    logic [WW-1:0] wait_cnt;

    cps_sync #(.W(2), .RST_VAL(2'b01)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({init_in, prog_n}),
        .q_sync  (sync_q)
    );

    assign prog_req = ~sync_q[0];
    assign init_hi  = sync_q[1];

    cps_por_timer #(.BASE(POR_CYCLES), .MULT(MASTER_MULT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .master (mode_master),
        .busy   (por_busy)
    );

    cps_frame_ctr #(.FRAMES(FRAMES)) u_frames (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (clr_en),
        .zero  (ctr_zero),
        .addr  (frame_addr),
        .last  (frame_last)
    );

    // Next-state decision; a request from any other state restarts the clear.
    always_comb begin
        state_n  = state;
        ctr_zero = 1'b0;
        unique case (state)
            ST_CLEAR: if (frame_last && !por_busy && !prog_req) state_n = ST_EXTRA;
            ST_EXTRA: if (frame_last) state_n = ST_INITW;
            ST_INITW: if (init_hi) state_n = ST_WAIT2;
            ST_WAIT2: begin
                if (!init_hi)                    state_n = ST_INITW;
                else if (wait_cnt == WAIT_LAST)  state_n = ST_READY;
            end
            ST_READY: state_n = ST_READY;
            default:  state_n = ST_CLEAR;
        endcase
        if (prog_req && state != ST_CLEAR) begin
            state_n  = ST_CLEAR;
            ctr_zero = 1'b1;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_CLEAR;
        else        state <= state_n;
    end

    // Settle counter, running only while in the settle state.
    always_ff @(posedge clk) begin
        if (!rst_n || state_n != ST_WAIT2 || state != ST_WAIT2) wait_cnt <= '0;
        else                                                    wait_cnt <= wait_cnt + 1'b1;
    end

    // Mode latch: cleared by a request, loaded on entry to ready.
    always_ff @(posedge clk) begin
        if (!rst_n || prog_req)                       mode_lat <= 1'b0;
        else if (state == ST_WAIT2 && state_n == ST_READY) mode_lat <= mode_master;
    end

    // Outputs decoded from the state.
    assign clr_en   = (state == ST_CLEAR) || (state == ST_EXTRA);
    assign init_low = clr_en;
    assign load_rdy = (state == ST_READY);
    assign hdc      = ~load_rdy;
    assign ldc      = load_rdy;
    assign done     = 1'b0;
endmodule

// File: rtl/cps_chk.sv
// Module: cps_chk
// Property checker for cfg_powerup_seq, attached by the bind below.
// Watches ports and the synchronized request and INIT levels.
module cps_chk #(
    parameter int unsigned FRAMES = 16,
    localparam int unsigned AW = (FRAMES > 2) ? $clog2(FRAMES) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_en,
    input logic [AW-1:0] frame_addr,
    input logic          init_low,
    input logic          load_rdy,
    input logic          mode_lat,
    input logic          hdc,
    input logic          ldc,
    input logic          prog_req,
    input logic          init_hi
);
    localparam logic [AW-1:0] LAST_A = AW'(FRAMES - 1);

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !prog_req && frame_addr != LAST_A) |=> frame_addr == $past(frame_addr) + 1'b1);

    // R2
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !prog_req && frame_addr == LAST_A) |=> frame_addr == '0);

    // R4
    release_at_pass_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(init_low) |-> ($past(frame_addr) == LAST_A && $past(clr_en)));

    // R5
    status_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hdc != ldc) && (ldc == load_rdy));

    // R6
    hold_while_init_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_hi && !load_rdy) |=> !load_rdy);

    // R7
    settle_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_rdy) |-> ($past(init_hi, 1) && $past(init_hi, 2) && $past(init_hi, 3)));

    // R8
    request_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> (init_low && !load_rdy && !mode_lat));
endmodule

bind cfg_powerup_seq cps_chk #(.FRAMES(FRAMES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_en     (clr_en),
    .frame_addr (frame_addr),
    .init_low   (init_low),
    .load_rdy   (load_rdy),
    .mode_lat   (mode_lat),
    .hdc        (hdc),
    .ldc        (ldc),
    .prog_req   (prog_req),
    .init_hi    (init_hi)
);

// File: tb/cfg_powerup_seq_tb.sv
`timescale 1ns/1ps
module cfg_powerup_seq_tb;
    localparam int FR   = 16;
    localparam int POR  = 40;
    localparam int MULT = 4;
    localparam int AW   = $clog2(FR);
    localparam int WD   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_n = 1'b1;
    logic init_in = 1'b1;
    logic mode_master = 1'b1;
    logic clr_en, init_low, hdc, ldc, done, mode_lat, load_rdy;
    logic [AW-1:0] frame_addr;

    int cyc = 0;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int exp_rel[$];
    int exp_rdy[$];
    bit exp_mode[$];

    cfg_powerup_seq #(.FRAMES(FR), .POR_CYCLES(POR), .MASTER_MULT(MULT)) u_dut (
        .clk(clk), .rst_n(rst_n), .prog_n(prog_n), .init_in(init_in),
        .mode_master(mode_master), .clr_en(clr_en), .frame_addr(frame_addr),
        .init_low(init_low), .hdc(hdc), .ldc(ldc), .done(done),
        .mode_lat(mode_lat), .load_rdy(load_rdy)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Edge of INIT release after reset, from R3/R4.
    function automatic int rel_edge(input int limit);
        return FR * ((limit + FR) / FR + 1);
    endfunction

    // Monitor: pops expected release and ready events as they appear.
    logic prev_il = 1'b0, prev_rdy = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_il === 1'b1 && init_low === 1'b0) begin
                if (exp_rel.size() == 0) check(1'b0, "R4", "unexpected INIT release", cyc, -1);
                else begin
                    int e;
                    e = exp_rel.pop_front();
                    check(cyc == e, "R4", "INIT release edge", cyc, e);
                end
            end
            if (prev_rdy === 1'b0 && load_rdy === 1'b1) begin
                if (exp_rdy.size() == 0) check(1'b0, "R7", "unexpected ready", cyc, -1);
                else begin
                    int e;
                    bit m;
                    e = exp_rdy.pop_front();
                    m = exp_mode.pop_front();
                    check(cyc == e, "R7", "ready edge", cyc, e);
                    check(mode_lat == m, "R7", "latched mode", mode_lat, m);
                end
            end
        end
        prev_il  = init_low;
        prev_rdy = load_rdy;
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Driver: power-on reset with the strap, pushing expected events.
    task automatic power_on(input bit master, input bit init_ready, output int base);
        int limit;
        @(negedge clk);
        rst_n = 1'b0;
        mode_master = master;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(clr_en && init_low && hdc && !ldc && !done && !load_rdy && !mode_lat
              && frame_addr == 0, "R1", "reset outputs", {clr_en, init_low, hdc, ldc, done, load_rdy, mode_lat}, 7'b1110000);
        rst_n = 1'b1;
        base = cyc;
        limit = master ? POR * MULT : POR;
        exp_rel.push_back(base + rel_edge(limit));
        if (init_ready) begin
            exp_rdy.push_back(base + rel_edge(limit) + 3);
            exp_mode.push_back(master);
        end
    endtask

    initial begin
        int b, c, d, r;
        // Scenario 1: master-serial power-on, INIT already free.
        init_in = 1'b1;
        power_on(1'b1, 1'b1, b);
        wait_to(b + 1);
        check(clr_en && frame_addr == 1, "R1", "first cycle after reset", frame_addr, 1);
        wait_to(b + 5);
        check(frame_addr == 5, "R2", "address steps", frame_addr, 5);
        wait_to(b + 17);
        check(frame_addr == 1, "R2", "address wrap", frame_addr, 1);
        check(hdc && !ldc && !done && init_low, "R5", "status while clearing", {hdc, ldc}, 2'b10);
        r = b + rel_edge(POR * MULT);
        wait_to(r - 1);
        check(init_low == 1'b1, "R3", "still clearing before long time-out pass", init_low, 1);
        wait_to(r + 3);
        check(load_rdy && !hdc && ldc && !clr_en && !done, "R5", "status after hand-off",
              {load_rdy, hdc, ldc}, 3'b101);
        check(mode_lat == 1'b1, "R7", "master mode latched", mode_lat, 1);

        // Scenario 2: request while ready, INIT held low from outside.
        init_in = 1'b0;
        c = cyc;
        prog_n = 1'b0;
        wait_to(c + 2);
        check(load_rdy == 1'b1, "R8", "request not yet through synchronizer", load_rdy, 1);
        wait_to(c + 3);
        check(init_low && !load_rdy && !mode_lat && frame_addr == 0 && hdc && !ldc,
              "R8", "request returns to clear", {init_low, load_rdy, mode_lat}, 3'b100);
        wait_to(c + 40);
        prog_n = 1'b1;
        exp_rel.push_back(c + 67);
        wait_to(c + 66);
        check(init_low == 1'b1, "R8", "time-out not restarted, extra pass running", init_low, 1);
        wait_to(c + 90);
        check(!init_low && !load_rdy, "R6", "waits while INIT held low", load_rdy, 0);
        mode_master = 1'b0;
        init_in = 1'b1;
        d = cyc;
        exp_rdy.push_back(d + 5);
        exp_mode.push_back(1'b0);
        wait_to(d + 4);
        check(load_rdy == 1'b0, "R7", "settle clocks observed", load_rdy, 0);
        wait_to(d + 6);
        check(load_rdy && mode_lat == 1'b0, "R7", "ready with non-master mode", mode_lat, 0);

        // Scenario 3: short time-out power-on.
        power_on(1'b0, 1'b1, b);
        r = b + rel_edge(POR);
        wait_to(r - 1);
        check(init_low == 1'b1, "R4", "extra pass before release", init_low, 1);
        wait_to(r + 4);
        check(load_rdy && !mode_lat && !done, "R9", "done low at hand-off", done, 0);

        wait_to(cyc + 4);
        check(exp_rel.size() == 0 && exp_rdy.size() == 0, "R4", "all expected events seen",
              exp_rel.size() + exp_rdy.size(), 0);
        finish_run();
    end

    initial begin
        repeat (WD) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected<%0d cycles", WD, WD);
        finish_run();
    end
endmodule